// File: doc/BRIEF.md
# CPU Bus Cycle Sequencer

This block produces the state-by-state timing of the external bus cycles of a small 8-bit processor. A requester presents a cycle kind (memory read, memory write, port read, port write) with an address and write data. The block then runs one bus cycle. It drives the active-low memory and port request strobes, the read and write strobes, the address bus and the outgoing data bus. When the cycle ends, it returns a one-clock completion pulse and, for reads, the byte it captured.

Each bus state lasts one clock. A memory cycle raises its memory request in the first state and samples the active-low stall input at the end of the second state. A port cycle raises its port request one state later. It always inserts one built-in wait state, and the stall input is first sampled at the end of that state. For port cycles, the port number goes on the low address byte. The high byte carries either the accumulator or the B register, as the request chooses. A memory cycle drives the full 16-bit address unchanged.

Top module: `cpu_bus_seq`

## Requirements
- R1: While reset is held and after it is released, all four strobes are high, `req_ready` is 1, `rsp_done` is 0 and `bus_dout_en` is 0.
- R2: A request is taken when `req_valid` is 1 in a clock where `req_ready` is 1. `req_kind` bit 1 selects a port cycle (1) or a memory cycle (0). `req_kind` bit 0 selects a write (1) or a read (0). A memory cycle with no stall lasts exactly 3 clocks, and `mreq_n` is low in its first two.
- R3: In a read, `rd_n` is low for the same states as the request strobe. The byte on `bus_din` at the clock edge that ends the last state before the final state is returned on `rsp_rdata` while `rsp_done` is 1.
- R4: In a write, `bus_dout_en` is 1 and `bus_dout` equals the request's write data in every state of the cycle. `wr_n` is low from the second state up to, but not including, the final state.
- R5: A port cycle asserts `iorq_n` from its second state and always inserts one automatic wait state. `wait_n` is ignored at the end of the second state. A port cycle with no stall lasts exactly 4 clocks.
- R6: Each `wait_n` sampled low at the end of the second state of a memory cycle, or at the end of a wait state, adds one more wait state. There is no limit on the number of wait states.
- R7: In a memory cycle, `bus_addr` equals `req_addr`. In a port cycle, `bus_addr[7:0]` is `req_addr[7:0]`, and `bus_addr[15:8]` is `req_acc` when `req_hi_sel` is 0 and `req_breg` when it is 1. The address stays constant for the whole cycle.
- R8: In the final state of a cycle, all strobes are high. `mreq_n` and `iorq_n` are never low together, and neither are `rd_n` and `wr_n`.
- R9: `rsp_done` is 1 for exactly the final clock of each cycle. `req_ready` is 0 for the whole cycle and is 1 again in the clock after `rsp_done`, so a new request can be taken there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Bit 1: port cycle; bit 0: write |
| req_addr | input | 16 | Memory address, or port number in the low byte |
| req_wdata | input | 8 | Write data |
| req_hi_sel | input | 1 | Port-cycle high byte: 0 accumulator, 1 B register |
| req_acc | input | 8 | Accumulator value for the high address byte |
| req_breg | input | 8 | B register value for the high address byte |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_done | output | 1 | One-clock completion pulse in the final state |
| rsp_rdata | output | 8 | Captured read data |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Outgoing data bus |
| bus_dout_en | output | 1 | Outgoing data bus enable |
| bus_din | input | 8 | Incoming data bus |
| mreq_n | output | 1 | Memory request, active low |
| iorq_n | output | 1 | Port request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wait_n | input | 1 | Stall input, sampled synchronously, active low |

## Verification
The assertions assume that `wait_n` and `bus_din` are stable around each rising edge, that `req_valid` is only acted on while `req_ready` is high, and that reset is applied from time zero. The stimulus meets these assumptions by changing every input only on falling edges and by raising `req_valid` only in idle clocks. The stimulus sweeps every cycle kind against zero to three stalls, both high-byte selections and several addresses. It holds `wait_n` low during the second state of port cycles, so any early sampling of the stall input would lengthen the cycle and show up as an error.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_TWA  = 3'd3,
      ST_TW   = 3'd4,
      ST_T3   = 3'd5
   } bus_state_e;

   typedef struct packed {
      logic io;
      logic wr;
   } cyc_kind_t;

endpackage

// File: rtl/cpu_bus_fsm.sv
module cpu_bus_fsm
   import cpu_bus_pkg::*;
#(
   parameter int IO_AUTO_WAITS = 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cyc_io,
   input  logic       wait_n,
   output bus_state_e state,
   output logic       to_final
);

   bus_state_e nxt;
   logic       auto_last;

   if (IO_AUTO_WAITS < 1) begin : g_bad_auto
      $error("IO_AUTO_WAITS must be at least 1");
   end

   if (IO_AUTO_WAITS == 1) begin : g_auto_single
      assign auto_last = 1'b1;
   end else begin : g_auto_count
      localparam int CW = $clog2(IO_AUTO_WAITS);
      localparam logic [CW-1:0] LAST = CW'(IO_AUTO_WAITS - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt <= '0;
         else if (state != ST_TWA)   cnt <= '0;
         else if (cnt != LAST)       cnt <= cnt + 1'b1;
      end
      assign auto_last = (cnt == LAST);
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: nxt = start ? ST_T1 : ST_IDLE;
         ST_T1:   nxt = ST_T2;
         ST_T2:   nxt = cyc_io ? ST_TWA : (wait_n ? ST_T3 : ST_TW);
         ST_TWA:  nxt = auto_last ? (wait_n ? ST_T3 : ST_TW) : ST_TWA;
         ST_TW:   nxt = wait_n ? ST_T3 : ST_TW;
         ST_T3:   nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign to_final = (state != ST_T3) && (nxt == ST_T3);

   AST_MEM_STALL_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2 && !cyc_io && !wait_n) |=> (state == ST_TW)); // R6
   AST_IO_AUTO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T2 && cyc_io) |=> (state == ST_TWA)); // R5
   AST_FINAL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_T3) |=> (state == ST_IDLE)); // R9

endmodule

// File: rtl/cpu_bus_req_reg.sv
module cpu_bus_req_reg
   import cpu_bus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int PORT_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [1:0]        kind_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] breg_in,
   output cyc_kind_t         kind,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata
);

   localparam int HI_W = ADDR_W - PORT_W;

   if (PORT_W < 1 || HI_W < 1) begin : g_bad_split
      $error("address must be wider than the port field");
   end

   logic [DATA_W-1:0] hi_reg;
   logic [HI_W-1:0]   hi_fit;
   logic [ADDR_W-1:0] io_addr;

   assign hi_reg = hi_sel ? breg_in : acc_in;

   if (HI_W >= DATA_W) begin : g_hi_pad
      assign hi_fit = HI_W'(hi_reg);
   end else begin : g_hi_trunc
      assign hi_fit = hi_reg[HI_W-1:0];
   end

   assign io_addr = {hi_fit, addr_in[PORT_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind  <= '0;
         addr  <= '0;
         wdata <= '0;
      end else if (load) begin
         kind  <= cyc_kind_t'(kind_in);
         addr  <= kind_in[1] ? io_addr : addr_in;
         wdata <= wdata_in;
      end
   end

endmodule

// File: rtl/cpu_bus_strobes.sv
module cpu_bus_strobes
   import cpu_bus_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  bus_state_e state,
   input  cyc_kind_t  kind,
   output logic       mreq_n,
   output logic       iorq_n,
   output logic       rd_n,
   output logic       wr_n,
   output logic       dout_en
);

   logic from_t1, from_t2, busy;

   assign from_t1 = (state == ST_T1) || from_t2;
   assign from_t2 = (state == ST_T2) || (state == ST_TWA) || (state == ST_TW);
   assign busy    = (state != ST_IDLE);

   always_comb begin
      mreq_n  = !(!kind.io && from_t1);
      iorq_n  = !( kind.io && from_t2);
      rd_n    = !(!kind.wr && (kind.io ? from_t2 : from_t1));
      wr_n    = !( kind.wr && from_t2);
      dout_en = kind.wr && busy;
   end

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mreq_n && !iorq_n)); // R8
   AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R8

endmodule

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
   import cpu_bus_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int PORT_W        = 8,
   parameter int IO_AUTO_WAITS = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_hi_sel,
   input  logic [DATA_W-1:0] req_acc,
   input  logic [DATA_W-1:0] req_breg,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_en,
   input  logic [DATA_W-1:0] bus_din,
   output logic              mreq_n,
   output logic              iorq_n,
   output logic              rd_n,
   output logic              wr_n,
   input  logic              wait_n
);

   bus_state_e state;
   cyc_kind_t  kind;
   logic       start, to_final;

   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid && req_ready;
   assign rsp_done  = (state == ST_T3);

   cpu_bus_req_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PORT_W (PORT_W)
   ) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .kind_in  (req_kind),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .hi_sel   (req_hi_sel),
      .acc_in   (req_acc),
      .breg_in  (req_breg),
      .kind     (kind),
      .addr     (bus_addr),
      .wdata    (bus_dout)
   );

   cpu_bus_fsm #(
      .IO_AUTO_WAITS (IO_AUTO_WAITS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cyc_io   (kind.io),
      .wait_n   (wait_n),
      .state    (state),
      .to_final (to_final)
   );

   cpu_bus_strobes u_strb (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .kind    (kind),
      .mreq_n  (mreq_n),
      .iorq_n  (iorq_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .dout_en (bus_dout_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rsp_rdata <= '0;
      else if (to_final && !kind.wr)  rsp_rdata <= bus_din;
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R9
   AST_STROBES_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (mreq_n && iorq_n && rd_n && wr_n)); // R8
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(bus_addr)); // R7
   AST_IOREQ_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iorq_n) |=> (!iorq_n && !rsp_done)); // R5
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mreq_n || !iorq_n) |-> !req_ready); // R9

endmodule

// File: tb/tb_cpu_bus_seq.sv
module tb_cpu_bus_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_hi_sel = 1'b0;
   logic [7:0]  req_acc = '0;
   logic [7:0]  req_breg = '0;
   logic        req_ready, rsp_done, bus_dout_en;
   logic [7:0]  rsp_rdata, bus_dout;
   logic [15:0] bus_addr;
   logic [7:0]  bus_din = '0;
   logic        mreq_n, iorq_n, rd_n, wr_n;
   logic        wait_n = 1'b1;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   cpu_bus_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_hi_sel(req_hi_sel),
      .req_acc(req_acc), .req_breg(req_breg), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
      .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
      .wait_n(wait_n)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One bus cycle; called and returns at a falling edge in an idle clock.
   task automatic run_cycle(input logic [1:0] kind, input int nw, input logic hsel,
                            input logic [15:0] addr, input logic [7:0] wd,
                            input logic [7:0] acc, input logic [7:0] breg,
                            input logic [7:0] dbase);
      logic io, wr;
      int len, first_sample;
      logic [15:0] exp_addr;
      io = kind[1];
      wr = kind[0];
      len = (io ? 4 : 3) + nw;
      first_sample = io ? 3 : 2;
      exp_addr = io ? {(hsel ? breg : acc), addr[7:0]} : addr;
      check("R9 ready before request", {63'd0, req_ready}, 64'd1);
      req_valid = 1'b1; req_kind = kind; req_addr = addr; req_wdata = wd;
      req_hi_sel = hsel; req_acc = acc; req_breg = breg;
      @(negedge clk);
      req_valid = 1'b0;
      req_acc = ~acc; req_breg = ~breg; req_addr = ~addr; req_wdata = ~wd;
      for (int k = 1; k <= len; k++) begin
         logic busy_m, busy_io, e_rd, e_wr;
         // R6 stall low for nw sampling points; R5 stall low during port T2 is ignored
         if (k >= first_sample && k < first_sample + nw) wait_n = 1'b0;
         else if (io && k == 2)                           wait_n = 1'b0;
         else                                             wait_n = 1'b1;
         bus_din = dbase ^ 8'(k);
         busy_m  = !io && k < len;
         busy_io = io && k >= 2 && k < len;
         e_rd    = !wr && (busy_m || busy_io);
         e_wr    = wr && k >= 2 && k < len;
         check("R2 mreq_n", {63'd0, mreq_n}, {63'd0, !busy_m});
         check("R5 iorq_n", {63'd0, iorq_n}, {63'd0, !busy_io});
         check("R3 rd_n", {63'd0, rd_n}, {63'd0, !e_rd});
         check("R4 wr_n", {63'd0, wr_n}, {63'd0, !e_wr});
         check("R4 bus_dout_en", {63'd0, bus_dout_en}, {63'd0, wr});
         if (wr) check("R4 bus_dout", {56'd0, bus_dout}, {56'd0, wd});
         check("R7 bus_addr", {48'd0, bus_addr}, {48'd0, exp_addr});
         check("R9 rsp_done", {63'd0, rsp_done}, {63'd0, k == len});
         check("R9 ready low in cycle", {63'd0, req_ready}, 64'd0);
         if (k == len) check("R8 strobes at end", {60'd0, mreq_n, iorq_n, rd_n, wr_n}, 64'hF);
         if (k == len && !wr)
            check("R3 rsp_rdata", {56'd0, rsp_rdata}, {56'd0, dbase ^ 8'(len - 1)});
         @(negedge clk);
      end
      wait_n = 1'b1;
      check("R9 ready after done", {63'd0, req_ready}, 64'd1);
      check("R9 done cleared", {63'd0, rsp_done}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset strobes", {60'd0, mreq_n, iorq_n, rd_n, wr_n}, 64'hF);
      check("R1 reset ready/done/en", {61'd0, req_ready, rsp_done, bus_dout_en}, 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {58'd0, mreq_n, iorq_n, rd_n, wr_n, req_ready, rsp_done}, 64'b111110);
      for (int kd = 0; kd < 4; kd++) begin
         for (int nw = 0; nw < 4; nw++) begin
            for (int hs = 0; hs < 2; hs++) begin
               for (int a = 0; a < 3; a++) begin
                  logic [15:0] ad;
                  ad = 16'(16'h1234 * (a + 1) + kd * 16'h0101 + nw * 16'h0F0F);
                  run_cycle(2'(kd), nw, hs[0], ad, 8'(8'h5A + a * 17 + nw),
                            8'(8'hA0 + kd + a), 8'(8'h3C ^ (nw * 7 + a)),
                            8'(8'h81 + kd * 13 + nw * 3 + a));
               end
            end
         end
      end
      // R6 long stall on a memory read, R5 long stall on a port write
      run_cycle(2'b00, 20, 1'b0, 16'hFFFF, 8'h00, 8'h11, 8'h22, 8'hC3);
      run_cycle(2'b11, 17, 1'b1, 16'h00FE, 8'hE7, 8'h44, 8'h99, 8'h0F);
      run_cycle(2'b10, 0, 1'b0, 16'h0000, 8'h00, 8'hFF, 8'h00, 8'h70);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule